// File: doc/BRIEF.md
# Slave Port Arbiter with Parking

This block decides which of up to twelve bus masters owns one slave port. Every master raises a request line and carries a 2-bit priority for this slave. When the slave is free, the highest priority requester wins and equal priorities take turns. An owner keeps the slave until it signals the end of its burst or until its tenure reaches a programmable cycle limit. When the limit is reached the burst is cut so that waiting masters can get in.

When nobody is requesting, the slave is parked. It can park on no master, on the master that owned it last, or on a fixed master chosen by a 4-bit index. A master that finds the slave parked on itself starts with no added latency. Any other master sees its grant one cycle after it requests. The grant is a registered one-hot vector. Address decode and data steering are left to the surrounding fabric.

Top module: `slv_port_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `grant_o` is all zeros and `connected_o` and `slot_expired_o` are low.
- R2: When the slave is arbitrated, the winner is a requester with the largest priority value. Master m's priority is `prio_i[2m+1:2m]`, and 3 is the highest.
- R3: Among requesters of equal top priority, the search starts at the index one above the last granted master and wraps from N-1 to 0.
- R4: A requester that the slave is not parked on sees its `grant_o` bit in the cycle after the cycle in which it requested, and it holds ownership from then on.
- R5: If the parked master raises its request, it becomes owner at once. `grant_o` stays unchanged, even when other masters with higher priority request in the same cycle.
- R6: While a tenure runs, `grant_o` does not change until a cycle with `burst_end_i` high or with `slot_expired_o` high. Requests that arrive during the tenure are held off.
- R7: With `slot_limit_i` = L, where L is not 0, `slot_expired_o` is high in the L-th cycle of a tenure, provided `burst_end_i` is low in that cycle. In the next cycle the grant moves to the best other requester. If there is none, the owner keeps the slave and a fresh count starts.
- R8: With `slot_limit_i` = 0, `slot_expired_o` never rises and a tenure lasts until `burst_end_i`.
- R9: Park mode 0 (and the unused code 3) leaves `grant_o` all zeros whenever the slave is idle.
- R10: Park mode 1 parks the slave on the master granted most recently. Before any grant has been made, the slave parks on no master.
- R11: Park mode 2 parks the slave on master `park_idx_i`. An index of N or above parks the slave on no master.
- R12: `connected_o` is high exactly when `grant_o` has a bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N (12) | Per-master request for a new tenure |
| prio_i | input | 2*N (24) | Per-master priority, 2 bits each, master m at bits 2m+1:2m |
| burst_end_i | input | 1 | The owner's current beat is the last beat of its burst |
| slot_limit_i | input | 9 | Maximum tenure length in cycles; 0 means no limit |
| park_mode_i | input | 2 | 0 none, 1 last owner, 2 fixed index, 3 treated as none |
| park_idx_i | input | 4 | Master index used for fixed parking |
| grant_o | output | N (12) | Registered one-hot grant, or zero |
| connected_o | output | 1 | The slave is connected to some master |
| slot_expired_o | output | 1 | The tenure is being cut in this cycle |

## Verification
A wrong round-robin pointer or a wrong last-owner record shows up at `grant_o` one cycle after the next arbitration or release. The scenarios place equal-priority requesters on both sides of the pointer and park in "last" mode right after different owners, so such an error appears within a cycle. An off-by-one in the tenure counter moves the `slot_expired_o` pulse by one cycle, and the bench checks that pulse on an exact cycle. A lost ownership flag lets a waiting master take the slave in the middle of a burst. The long run with an unlimited slot and a higher-priority contender exposes that at the first cycle where it happens.

// File: rtl/spa_pkg.sv
package spa_pkg;

    // how the slave behaves when no master requests it
    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_mode_e;

endpackage

// File: rtl/spa_pick.sv
// Priority pick with round-robin tie break, purely combinational.
module spa_pick #(
    parameter int N  = 12,
    parameter int PW = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic [IW-1:0]   ptr_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);

    logic [PW-1:0] prio_m [N];
    logic [PW-1:0] top_prio;
    logic [N-1:0]  cand;

    for (genvar m = 0; m < N; m++) begin : g_unpack
        assign prio_m[m] = prio_i[m*PW +: PW];
    end

    always_comb begin
        top_prio = '0;
        for (int m = 0; m < N; m++) begin
            if (req_i[m] && (prio_m[m] > top_prio)) begin
                top_prio = prio_m[m];
            end
        end
        for (int m = 0; m < N; m++) begin
            cand[m] = req_i[m] && (prio_m[m] == top_prio);
        end
    end

    // scan from ptr+1 upwards, wrapping, so the last winner comes last
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= N; k++) begin
            int pos;
            pos = (int'(ptr_i) + k) % N;
            if (!valid_o && cand[pos]) begin
                valid_o = 1'b1;
                idx_o   = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/spa_park_sel.sv
// Chooses the master the slave rests on while idle.
module spa_park_sel
    import spa_pkg::*;
#(
    parameter int N  = 12,
    parameter int FW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  park_mode_e      mode_i,
    input  logic [FW-1:0]   fix_idx_i,
    input  logic [IW-1:0]   last_i,
    input  logic            seen_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        unique case (mode_i)
            PARK_LAST: begin
                valid_o = seen_i;
                idx_o   = last_i;
            end
            PARK_FIXED: begin
                if (int'(fix_idx_i) < N) begin
                    valid_o = 1'b1;
                    idx_o   = IW'(fix_idx_i);
                end
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spa_slot_timer.sv
// Counts the cycles of one tenure and flags when the limit is reached.
module spa_slot_timer #(
    parameter int SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic          end_i,
    input  logic [SW-1:0] limit_i,
    output logic          expire_o
);

    logic [SW-1:0] cnt_d, cnt_q;
    logic [SW:0]   cnt_nxt;

    always_comb begin
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;
    assign expire_o = run_i && !end_i && (limit_i != '0) && (cnt_nxt >= {1'b0, limit_i});

endmodule

// File: rtl/slv_port_arbiter.sv
module slv_port_arbiter
    import spa_pkg::*;
#(
    parameter int N  = 12,
    parameter int PW = 2,
    parameter int SW = 9,
    parameter int FW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic            burst_end_i,
    input  logic [SW-1:0]   slot_limit_i,
    input  logic [1:0]      park_mode_i,
    input  logic [FW-1:0]   park_idx_i,
    output logic [N-1:0]    grant_o,
    output logic            connected_o,
    output logic            slot_expired_o
);

    typedef struct packed {
        logic          busy;
        logic          valid;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
        logic          seen;
    } arb_state_t;

    arb_state_t    st_d, st_q;
    logic [N-1:0]  owner_oh;
    logic [N-1:0]  pick_mask;
    logic          pick_valid;
    logic [IW-1:0] pick_idx;
    logic          park_valid;
    logic [IW-1:0] park_idx;
    logic          slot_exp;
    logic          restart;
    logic          parked_hit;

    assign owner_oh = {{(N-1){1'b0}}, 1'b1} << st_q.owner;

    spa_pick #(.N(N), .PW(PW)) u_pick (
        .req_i   (pick_mask),
        .prio_i  (prio_i),
        .ptr_i   (st_q.last),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    spa_park_sel #(.N(N), .FW(FW)) u_park (
        .mode_i    (park_mode_e'(park_mode_i)),
        .fix_idx_i (park_idx_i),
        .last_i    (st_q.last),
        .seen_i    (st_q.seen),
        .valid_o   (park_valid),
        .idx_o     (park_idx)
    );

    spa_slot_timer #(.SW(SW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.busy),
        .restart_i (restart),
        .end_i     (burst_end_i),
        .limit_i   (slot_limit_i),
        .expire_o  (slot_exp)
    );

    always_comb begin
        st_d       = st_q;
        restart    = 1'b0;
        pick_mask  = slot_exp ? (req_i & ~owner_oh) : req_i;
        parked_hit = !st_q.busy && st_q.valid && req_i[st_q.owner];

        if (!st_q.busy) begin
            if (parked_hit) begin
                st_d.busy = 1'b1;
                st_d.last = st_q.owner;
                st_d.seen = 1'b1;
                restart   = 1'b1;
            end else if (pick_valid) begin
                st_d.busy  = 1'b1;
                st_d.valid = 1'b1;
                st_d.owner = pick_idx;
                st_d.last  = pick_idx;
                st_d.seen  = 1'b1;
                restart    = 1'b1;
            end else begin
                st_d.valid = park_valid;
                st_d.owner = park_idx;
            end
        end else if (burst_end_i || slot_exp) begin
            if (pick_valid) begin
                st_d.valid = 1'b1;
                st_d.owner = pick_idx;
                st_d.last  = pick_idx;
                st_d.seen  = 1'b1;
                restart    = 1'b1;
            end else if (slot_exp) begin
                restart = 1'b1;
            end else begin
                st_d.busy  = 1'b0;
                st_d.valid = park_valid;
                st_d.owner = park_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o        = st_q.valid ? owner_oh : '0;
    assign connected_o    = st_q.valid;
    assign slot_expired_o = slot_exp;

    // R4
    grant_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && req_i != '0) |=> (st_q.busy && ((grant_o & $past(req_i)) != '0)));

    // R6
    hold_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !burst_end_i && !slot_expired_o) |=> $stable(grant_o));

    // R7
    slot_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_expired_o && ((req_i & ~grant_o) != '0)) |=> (grant_o != $past(grant_o)));

    // R9
    park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((park_mode_i == PARK_NONE) && req_i == '0 && (!st_q.busy || burst_end_i))
        |=> (grant_o == '0));

    // R11
    park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((park_mode_i == PARK_FIXED) && (int'(park_idx_i) < N) && req_i == '0
         && (!st_q.busy || burst_end_i))
        |=> (grant_o == ({{(N-1){1'b0}}, 1'b1} << $past(park_idx_i))));

endmodule

// File: tb/tb_slv_port_arbiter.sv
`timescale 1ns/1ps
module tb_slv_port_arbiter;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [2*N-1:0] prio = '0;
    logic          bend = 1'b0;
    logic [8:0]    limit = '0;
    logic [1:0]    mode = 2'd0;
    logic [3:0]    fidx = 4'd0;
    logic [N-1:0]  grant;
    logic          conn;
    logic          expd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [N-1:0] g;
        logic         e;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    slv_port_arbiter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req),
        .prio_i         (prio),
        .burst_end_i    (bend),
        .slot_limit_i   (limit),
        .park_mode_i    (mode),
        .park_idx_i     (fidx),
        .grant_o        (grant),
        .connected_o    (conn),
        .slot_expired_o (expd)
    );

    function automatic logic [N-1:0] b(input int i);
        return {{(N-1){1'b0}}, 1'b1} << i;
    endfunction

    // driver: apply this cycle's inputs just after a falling edge, queue the expectation
    task automatic cyc(input logic [N-1:0] r, input logic be, input logic [N-1:0] g,
                       input logic e, input string tag);
        req  = r;
        bend = be;
        sb.push_back('{g: g, e: e, tag: tag});
        @(negedge clk);
    endtask

    // monitor: compare outputs 1 ns after each falling edge
    initial begin
        forever begin
            exp_t it;
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (grant !== it.g) begin
                    errors++;
                    $display("FAIL %s grant actual %h expected %h", it.tag, grant, it.g);
                end
                checks++;
                if (conn !== (it.g != '0)) begin
                    errors++;
                    $display("FAIL R12 (%s) connected actual %b expected %b", it.tag, conn, it.g != '0);
                end
                checks++;
                if (expd !== it.e) begin
                    errors++;
                    $display("FAIL %s slot_expired actual %b expected %b", it.tag, expd, it.e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc('0, 0, '0, 0, "R1 in reset");
        cyc('0, 0, '0, 0, "R1 in reset");
        rst_n = 1'b1;
        cyc('0, 0, '0, 0, "R1 after reset");
        cyc(b(3), 0, '0, 0, "R4 first request");
        cyc(b(3), 0, b(3), 0, "R4 grant next cycle");
        cyc('0, 1, b(3), 0, "R6 last beat");
        mode = 2'd1;
        cyc('0, 0, '0, 0, "R9 none after release");
        cyc('0, 0, b(3), 0, "R10 park on last");
        cyc(b(3), 0, b(3), 0, "R5 parked request");
        cyc(b(3), 0, b(3), 0, "R6 tenure");
        cyc('0, 1, b(3), 0, "R6 last beat");
        cyc(b(5), 0, b(3), 0, "R10 still parked on 3");
        cyc(b(5), 0, b(5), 0, "R4 other master");
        cyc('0, 1, b(5), 0, "R6 last beat");
        mode = 2'd2;
        fidx = 4'd7;
        cyc('0, 0, b(5), 0, "R10 park on new last");
        cyc('0, 0, b(7), 0, "R11 park fixed");
        cyc(b(7), 0, b(7), 0, "R5 fixed parked request");
        cyc('0, 1, b(7), 0, "R6 last beat");
        fidx = 4'd13;
        cyc('0, 0, b(7), 0, "R11 back to fixed");
        fidx = 4'd7;
        cyc('0, 0, '0, 0, "R11 index out of range");
        mode = 2'd0;
        cyc('0, 0, b(7), 0, "R11 index restored");
        prio[2*2 +: 2] = 2'd3;
        prio[9*2 +: 2] = 2'd3;
        prio[4*2 +: 2] = 2'd1;
        cyc(b(2) | b(4) | b(9), 0, '0, 0, "R9 none mode idle");
        cyc(b(2) | b(4) | b(9), 0, b(9), 0, "R3 tie after pointer 7");
        cyc(b(2) | b(4), 1, b(9), 0, "R6 others wait");
        cyc(b(2) | b(4), 0, b(2), 0, "R2 high priority wins");
        cyc(b(2) | b(4) | b(9), 1, b(2), 0, "R6 tenure");
        cyc(b(2) | b(4), 1, b(9), 0, "R3 rotation skips 2");
        cyc(b(4), 1, b(2), 0, "R3 back to 2");
        cyc('0, 1, b(4), 0, "R2 low priority alone");
        prio  = '0;
        limit = 9'd3;
        cyc(b(1), 0, '0, 0, "R9 idle none");
        cyc(b(1) | b(6), 0, b(1), 0, "R7 tenure cycle 1");
        cyc(b(1) | b(6), 0, b(1), 0, "R7 tenure cycle 2");
        cyc(b(1) | b(6), 0, b(1), 1, "R7 expiry on cycle 3");
        cyc(b(6), 0, b(6), 0, "R7 handover");
        cyc(b(6), 0, b(6), 0, "R7 new count");
        cyc(b(6), 0, b(6), 1, "R7 expiry alone");
        cyc('0, 1, b(6), 0, "R7 owner kept");
        limit = 9'd0;
        cyc(b(1), 0, '0, 0, "R9 idle none");
        prio[6*2 +: 2] = 2'd3;
        for (int i = 0; i < 20; i++) begin
            cyc(b(1) | b(6), 0, b(1), 0, "R8 no limit R6 no preemption");
        end
        cyc('0, 1, b(1), 0, "R8 end of long burst");
        cyc('0, 0, '0, 0, "R9 final idle");
        while (sb.size() > 0) @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule